// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a state where it can accept row activations. Once reset is released it keeps the command lines at NOP through a long stabilization wait. It then issues a precharge to all banks, a parameterized number of auto-refresh commands (two by default) and a mode-register load. Every command is followed by a fixed gap counted in clock cycles. When the gap after the mode-register load has passed, the block raises a done flag. The memory controller then takes over the command bus.

The default parameters suit a 133 MHz memory clock, a 13-bit address bus and a 2-bit bank select:

| Step | Gap |
|---|---|
| Power-up wait | 26600 cycles (about 200 us) |
| Precharge recovery | 3 cycles |
| Each refresh | 10 cycles |
| Mode load to first activate | 2 cycles |

The mode word programmed into the device selects CAS latency 3, sequential bursts and a burst length of one. The block does not touch the data bus.

All outputs are registered. "Edge k" below means the k-th rising clock edge at which rst_n is sampled high after reset is released. Output values set at edge k are visible until edge k+1.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While rst_n is low, the command lines carry NOP, sd_addr and sd_ba are zero, and init_done is low.
- R2: The command group {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} uses these codes:

  | Command | Code |
  |---|---|
  | NOP | 4'b0111 |
  | precharge | 4'b0010 |
  | auto-refresh | 4'b0001 |
  | load-mode | 4'b0000 |

  No other code appears on the group.
- R3: The precharge-all command appears exactly at edge 26600 (the parameter WAIT_CYCLES). It drives sd_addr = 13'h0400 (only bit 10 set) and sd_ba = 0. Before that edge, every cycle after reset carries NOP.
- R4: The first auto-refresh appears exactly 3 edges after the precharge, at edge 26603.
- R5: The second auto-refresh appears exactly 10 edges after the first, at edge 26613. There are exactly two refresh commands in the sequence.
- R6: The load-mode command appears exactly 10 edges after the second refresh, at edge 26623. It drives sd_addr = 13'h0030 and sd_ba = 0. In that word, bits [2:0] = 000 give burst length 1, bit 3 = 0 gives sequential bursts, bits [6:4] = 011 give CAS latency 3, and all other bits are zero.
- R7: init_done rises exactly 2 edges after the load-mode command, at edge 26625. It stays high, with NOP on the command lines, until the next reset.
- R8: Every non-NOP command lasts exactly one cycle. All other cycles carry NOP.
- R9: A reset asserted part-way through the sequence returns the block to the R1 state. After the release the full sequence restarts with the same edge positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address pins (A10 for precharge-all, mode word on load) |
| sd_ba | output | 2 | Bank select pins |
| init_done | output | 1 | High once the device may be activated; sticky until reset |

## Verification
The hardest situation to reach is a reset that lands inside the command phase. Getting there requires first running the full 26600-cycle stabilization wait. The bench does this with its own cycle counter: it asserts reset between the two refresh commands, checks that the outputs fall back to idle, and then replays the entire sequence. The replay checks every command position again, which shows that neither the refresh count nor the timer kept any stale state. Each command is checked at its exact cycle index together with the address and bank values.

// File: rtl/sdram_pwrup_pkg.sv
package sdram_pwrup_pkg;

   // Command group order: {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      SD_LOADMODE = 4'b0000,
      SD_REFRESH  = 4'b0001,
      SD_PRECHG   = 4'b0010,
      SD_ACTIVATE = 4'b0011,
      SD_WRITE    = 4'b0100,
      SD_READ     = 4'b0101,
      SD_NOP      = 4'b0111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      PH_STABLE,
      PH_PRECHG,
      PH_REFRESH,
      PH_MODE,
      PH_READY
   } pwrup_phase_e;

   // Mode word:
   //   [2:0] burst length code
   //   [3]   burst type (0 = sequential)
   //   [6:4] CAS latency
   //   all other bits zero
   function automatic logic [15:0] mode_word(input int cas_lat,
                                             input int bl_code,
                                             input bit interleave);
      logic [15:0] w;
      w      = '0;
      w[2:0] = 3'(bl_code);
      w[3]   = interleave;
      w[6:4] = 3'(cas_lat);
      return w;
   endfunction

endpackage

// File: rtl/sdram_pwrup_timer.sv
module sdram_pwrup_timer #(
   parameter int TMR_W     = 15,
   parameter int RESET_VAL = 100
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [TMR_W-1:0] load_val,
   output logic             expired
);

   logic [TMR_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= TMR_W'(RESET_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_pwrup_fsm.sv
module sdram_pwrup_fsm
   import sdram_pwrup_pkg::*;
#(
   parameter int TMR_W      = 15,
   parameter int TRP_CYC    = 3,
   parameter int TRFC_CYC   = 10,
   parameter int TMRD_CYC   = 2,
   parameter int REF_COUNT  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             expired,
   output logic             tmr_load,
   output logic [TMR_W-1:0] tmr_val,
   output logic             issue,
   output sd_cmd_e          issue_cmd,
   output logic             ready_set
);

   localparam int RC_W = $clog2(REF_COUNT + 1);

   pwrup_phase_e    phase, phase_nx;
   logic [RC_W-1:0] ref_cnt, ref_cnt_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_STABLE;
         ref_cnt <= '0;
      end else begin
         phase   <= phase_nx;
         ref_cnt <= ref_cnt_nx;
      end
   end

   always_comb begin
      phase_nx   = phase;
      ref_cnt_nx = ref_cnt;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      issue      = 1'b0;
      issue_cmd  = SD_NOP;
      ready_set  = 1'b0;
      if (expired) begin
         unique case (phase)
            PH_STABLE: begin
               issue     = 1'b1;
               issue_cmd = SD_PRECHG;
               tmr_load  = 1'b1;
               tmr_val   = TMR_W'(TRP_CYC - 1);
               phase_nx  = PH_PRECHG;
            end
            PH_PRECHG, PH_REFRESH: begin
               if (phase == PH_REFRESH && ref_cnt == RC_W'(REF_COUNT)) begin
                  issue     = 1'b1;
                  issue_cmd = SD_LOADMODE;
                  tmr_load  = 1'b1;
                  tmr_val   = TMR_W'(TMRD_CYC - 1);
                  phase_nx  = PH_MODE;
               end else begin
                  issue      = 1'b1;
                  issue_cmd  = SD_REFRESH;
                  tmr_load   = 1'b1;
                  tmr_val    = TMR_W'(TRFC_CYC - 1);
                  ref_cnt_nx = ref_cnt + 1'b1;
                  phase_nx   = PH_REFRESH;
               end
            end
            PH_MODE: begin
               ready_set = 1'b1;
               phase_nx  = PH_READY;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/sdram_pwrup_cmd_drv.sv
module sdram_pwrup_cmd_drv
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W   = 13,
   parameter int BANK_W   = 2,
   parameter int AP_BIT   = 10,
   parameter logic [ADDR_W-1:0] MODE_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  sd_cmd_e           issue_cmd,
   input  logic              ready_set,
   output logic [3:0]        cmd_bus,
   output logic [ADDR_W-1:0] addr,
   output logic [BANK_W-1:0] bank,
   output logic              ready
);

   localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << AP_BIT;

   logic [ADDR_W-1:0] addr_sel;

   always_comb begin
      unique case (issue_cmd)
         SD_PRECHG:   addr_sel = PRE_ALL;
         SD_LOADMODE: addr_sel = MODE_VAL;
         default:     addr_sel = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_bus <= SD_NOP;
         addr    <= '0;
         bank    <= '0;
         ready   <= 1'b0;
      end else begin
         cmd_bus <= issue ? issue_cmd : SD_NOP;
         addr    <= issue ? addr_sel : '0;
         bank    <= '0;
         if (ready_set)
            ready <= 1'b1;
      end
   end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_pwrup_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int BANK_W      = 2,
   parameter int WAIT_CYCLES = 26600,
   parameter int TRP_CYC     = 3,
   parameter int TRFC_CYC    = 10,
   parameter int TMRD_CYC    = 2,
   parameter int REF_COUNT   = 2,
   parameter int CAS_LAT     = 3,
   parameter int BL_CODE     = 0,
   parameter bit INTERLEAVE  = 1'b0,
   parameter int AP_BIT      = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [ADDR_W-1:0] sd_addr,
   output logic [BANK_W-1:0] sd_ba,
   output logic              init_done
);

   localparam int MAX_GAP = (WAIT_CYCLES > TRFC_CYC) ? WAIT_CYCLES : TRFC_CYC;
   localparam int TMR_W   = $clog2(MAX_GAP + 1);
   localparam logic [15:0] MODE16 = mode_word(CAS_LAT, BL_CODE, INTERLEAVE);
   localparam logic [ADDR_W-1:0] MODE_VAL = MODE16[ADDR_W-1:0];

   generate
      if (ADDR_W < 11 || AP_BIT >= ADDR_W) begin : g_bad_addr
         $error("address bus too narrow for auto-precharge bit and mode word");
      end
      if (WAIT_CYCLES < 2 || TRP_CYC < 1 || TRFC_CYC < 1 || TMRD_CYC < 1) begin : g_bad_gap
         $error("every gap must be at least one cycle");
      end
      if (REF_COUNT < 1) begin : g_bad_ref
         $error("at least one refresh is required");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("unsupported CAS latency");
      end
   endgenerate

   logic             expired, tmr_load, issue, ready_set;
   logic [TMR_W-1:0] tmr_val;
   sd_cmd_e          issue_cmd;
   logic [3:0]       cmd_bus;

   sdram_pwrup_timer #(
      .TMR_W     (TMR_W),
      .RESET_VAL (WAIT_CYCLES - 1)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (expired)
   );

   sdram_pwrup_fsm #(
      .TMR_W     (TMR_W),
      .TRP_CYC   (TRP_CYC),
      .TRFC_CYC  (TRFC_CYC),
      .TMRD_CYC  (TMRD_CYC),
      .REF_COUNT (REF_COUNT)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .expired   (expired),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .issue     (issue),
      .issue_cmd (issue_cmd),
      .ready_set (ready_set)
   );

   sdram_pwrup_cmd_drv #(
      .ADDR_W   (ADDR_W),
      .BANK_W   (BANK_W),
      .AP_BIT   (AP_BIT),
      .MODE_VAL (MODE_VAL)
   ) u_drv (
      .clk       (clk),
      .rst_n     (rst_n),
      .issue     (issue),
      .issue_cmd (issue_cmd),
      .ready_set (ready_set),
      .cmd_bus   (cmd_bus),
      .addr      (sd_addr),
      .bank      (sd_ba),
      .ready     (init_done)
   );

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_bus;

endmodule

// File: rtl/sdram_pwrup_chk.sv
module sdram_pwrup_chk #(
   parameter int ADDR_W = 13,
   parameter int BANK_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sd_cs_n,
   input logic              sd_ras_n,
   input logic              sd_cas_n,
   input logic              sd_we_n,
   input logic [ADDR_W-1:0] sd_addr,
   input logic [BANK_W-1:0] sd_ba,
   input logic              init_done
);

   logic [3:0] cmd;
   assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   localparam logic [3:0] K_NOP = 4'b0111;
   localparam logic [3:0] K_PRE = 4'b0010;
   localparam logic [3:0] K_REF = 4'b0001;
   localparam logic [3:0] K_LMR = 4'b0000;

   a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == K_NOP || cmd == K_PRE || cmd == K_REF || cmd == K_LMR);

   a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      cmd != K_NOP |=> cmd == K_NOP);

   a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == K_PRE |-> sd_addr[10] && sd_ba == '0);

   a_r6_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == K_LMR |-> sd_addr == ADDR_W'(16'h0030) && sd_ba == '0);

   a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |=> init_done);

   a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      init_done |-> cmd == K_NOP);

   a_r7_done_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(init_done) |-> $past(cmd, 2) == K_LMR);

   a_r4_gap_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
      cmd == K_PRE |=> cmd == K_NOP ##1 cmd == K_NOP ##1 cmd == K_REF);

endmodule

bind sdram_pwrup_seq sdram_pwrup_chk #(
   .ADDR_W (ADDR_W),
   .BANK_W (BANK_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sd_cs_n   (sd_cs_n),
   .sd_ras_n  (sd_ras_n),
   .sd_cas_n  (sd_cas_n),
   .sd_we_n   (sd_we_n),
   .sd_addr   (sd_addr),
   .sd_ba     (sd_ba),
   .init_done (init_done)
);

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps
module sim_sdram_pwrup_seq;

   localparam int W       = 26600;
   localparam int E_PRE   = W;
   localparam int E_REF1  = W + 3;
   localparam int E_REF2  = W + 13;
   localparam int E_LMR   = W + 23;
   localparam int E_DONE  = W + 25;
   localparam logic [3:0] K_NOP = 4'b0111;
   localparam logic [3:0] K_PRE = 4'b0010;
   localparam logic [3:0] K_REF = 4'b0001;
   localparam logic [3:0] K_LMR = 4'b0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n, ras_n, cas_n, we_n, done;
   logic [12:0] addr;
   logic [1:0]  ba;
   logic [3:0]  cmd;
   int          n_chk = 0;
   int          n_bad = 0;

   always #5 clk = ~clk;
   assign cmd = {cs_n, ras_n, cas_n, we_n};

   sdram_pwrup_seq u0 (
      .clk (clk), .rst_n (rst_n),
      .sd_cs_n (cs_n), .sd_ras_n (ras_n), .sd_cas_n (cas_n), .sd_we_n (we_n),
      .sd_addr (addr), .sd_ba (ba), .init_done (done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // R1: outputs idle while reset is held
   task automatic t_reset_state();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(cmd == K_NOP, "R1 cmd", cmd, K_NOP);
      chk(addr == 0, "R1 addr", addr, 0);
      chk(ba == 0, "R1 ba", ba, 0);
      chk(done == 1'b0, "R1 done", done, 0);
   endtask

   // Walk edge by edge after release; expected values come from R2..R8
   task automatic t_sequence(input string tag, input int stop_at);
      int pre_at = -1, ref1_at = -1, ref2_at = -1, lmr_at = -1, done_at = -1;
      int n_ref = 0, stray_at = -1, pre_addr = -1, lmr_addr = -1, lmr_ba = -1;
      int nop_addr_bad = -1;
      for (int k = 1; k <= stop_at; k++) begin
         @(negedge clk);
         if (cmd == K_PRE && pre_at < 0) begin pre_at = k; pre_addr = addr; end
         else if (cmd == K_REF) begin
            n_ref++;
            if (ref1_at < 0) ref1_at = k; else if (ref2_at < 0) ref2_at = k;
         end
         else if (cmd == K_LMR && lmr_at < 0) begin lmr_at = k; lmr_addr = addr; lmr_ba = ba; end
         else if (cmd != K_NOP && stray_at < 0) stray_at = k;
         if (cmd == K_NOP && addr != 0 && nop_addr_bad < 0) nop_addr_bad = k;
         if (done && done_at < 0) done_at = k;
         if (done_at >= 0 && !done) done_at = -2;
      end
      if (stop_at < E_DONE) return;
      $display("sequence %s", tag);
      chk(pre_at == E_PRE, "R3 precharge edge", pre_at, E_PRE);
      chk(pre_addr == 13'h0400, "R3 precharge addr", pre_addr, 13'h0400);
      chk(ref1_at == E_REF1, "R4 first refresh edge", ref1_at, E_REF1);
      chk(ref2_at == E_REF2, "R5 second refresh edge", ref2_at, E_REF2);
      chk(n_ref == 2, "R5 refresh count", n_ref, 2);
      chk(lmr_at == E_LMR, "R6 load-mode edge", lmr_at, E_LMR);
      chk(lmr_addr == 13'h0030, "R6 mode word", lmr_addr, 13'h0030);
      chk(lmr_ba == 0, "R6 mode bank", lmr_ba, 0);
      chk(done_at == E_DONE, "R7 done edge", done_at, E_DONE);
      chk(stray_at < 0, "R2 stray code edge", stray_at, -1);
      chk(nop_addr_bad < 0, "R8 idle addr edge", nop_addr_bad, -1);
   endtask

   // R7/R8: after done, hold high and NOP
   task automatic t_hold_after_done();
      int bad_at = -1;
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if ((!done || cmd != K_NOP) && bad_at < 0) bad_at = k;
      end
      chk(bad_at < 0, "R7 done held with NOP", bad_at, -1);
   endtask

   // R9: reset between the refreshes, then full replay
   task automatic t_reset_midway();
      do_reset();
      t_sequence("partial", E_REF1 + 4);
      rst_n = 1'b0;
      @(negedge clk);
      chk(cmd == K_NOP && addr == 0 && !done, "R9 idle after midway reset", cmd, K_NOP);
      do_reset();
      t_sequence("R9 replay", E_DONE + 5);
   endtask

   initial begin
      t_reset_state();
      do_reset();
      t_sequence("R3 first run", E_DONE + 5);
      t_hold_after_done();
      t_reset_midway();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule